// File: doc/BRIEF.md
# Two-Level Carry Look-Ahead Adder

This block anticipates carries across a word without a ripple chain. Its building unit serves four adder groups. Each group reports a generate and a propagate signal, and both are active-low. From these and an active-high carry-in, the unit forms the carries into groups one, two and three as flat sum-of-products terms. It also forms a block-level generate and propagate, in the same active-low polarity. Because of that polarity, the unit can feed an identical unit one level higher.

The top module stacks the unit into a two-level tree over sixteen 4-bit adder slices to give a 64-bit add:

- Four first-level units each serve four slices.
- One second-level unit supplies the carry-ins of first-level units 1 to 3.
- The carry-out comes from the second-level block generate and propagate together with the carry-in.

The whole path is combinational and has no clock or reset.

Top module: `cla_adder64`

## Requirements
- R1: In `cla_unit`, with true generate g = ~gen_n and true propagate p = ~prop_n, the output c_grp[0] (carry into group 1) equals g0 | p0·c_in.
- R2: c_grp[1] (carry into group 2) equals g1 | p1·g0 | p1·p0·c_in.
- R3: c_grp[2] (carry into group 3) equals g2 | p2·g1 | p2·p1·g0 | p2·p1·p0·c_in.
- R4: blk_prop_n is low exactly when all four prop_n inputs are low.
- R5: blk_gen_n is low exactly when g3 | p3·g2 | p3·p2·g1 | p3·p2·p1·g0 holds.
- R6: blk_gen_n and blk_prop_n do not change when only c_in changes.
- R7: `sum` equals (a + b + cin) modulo 2^64 for every operand pair, including operands that make a carry travel the full word.
- R8: `cout` equals bit 64 of the 65-bit value a + b + cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0, active-high |
| sum | output | 64 | Sum bits |
| cout | output | 1 | Carry out of bit 63, active-high |

## Verification
Every result of the block is due in the same cycle as its stimulus, because no register lies anywhere between inputs and outputs. The bench changes inputs on the falling clock edge and reads the outputs one nanosecond after the next rising edge, so all logic has settled before each comparison. The 4-group unit is also instantiated on its own and driven through all 512 combinations of its inputs. The 64-bit tree sees directed corner operands and seeded random operands.

// File: rtl/cla_pkg.sv
// Package: cla_pkg
// Shared sizing for the carry look-ahead tree.
// Assumes every look-ahead unit serves exactly four groups.
package cla_pkg;
    localparam int GROUPS = 4;
    typedef logic [GROUPS-1:0] gp_vec_t;
endpackage

// File: rtl/cla_slice.sv
// Module: cla_slice
// One adder group of SLICE_W bits. It adds a and b with a supplied carry-in.
// It reports active-low generate and propagate for the whole group.
// Assumes propagate means every bit pair differs (a XOR b all ones).
module cla_slice #(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               c_in,
    output logic [SLICE_W-1:0] sum,
    output logic               gen_n,
    output logic               prop_n
);
    // Ripple add inside the narrow group only
    always_comb begin
        logic c;
        c = c_in;
        for (int i = 0; i < SLICE_W; i++) begin
            sum[i] = a[i] ^ b[i] ^ c;
            c      = (a[i] & b[i]) | ((a[i] ^ b[i]) & c);
        end
    end

    // Group generate and propagate, independent of c_in
    always_comb begin
        logic gt;
        gt = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            gt = (a[i] & b[i]) | ((a[i] ^ b[i]) & gt);
        end
        gen_n  = ~gt;
        prop_n = ~(&(a ^ b));
    end
endmodule

// File: rtl/cla_unit.sv
// Module: cla_unit
// Four-group carry anticipation unit. Generate and propagate are active-low.
// Carries are active-high. The block outputs can feed an identical unit above.
// Assumes inputs are settled; no clock, no reset.
module cla_unit
    import cla_pkg::*;
(
    input  gp_vec_t    gen_n,
    input  gp_vec_t    prop_n,
    input  logic       c_in,
    output logic [2:0] c_grp,
    output logic       blk_gen_n,
    output logic       blk_prop_n
);
    gp_vec_t g;
    gp_vec_t p;

    // Convert to true polarity
    always_comb begin
        g = ~gen_n;
        p = ~prop_n;
    end

    // Flat sum-of-products carries into groups 1..3
    always_comb begin
        c_grp[0] = g[0] | (p[0] & c_in);
        c_grp[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_in);
        c_grp[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                 | (p[2] & p[1] & p[0] & c_in);
    end

    // Block generate and propagate for the next level, active-low
    always_comb begin
        blk_prop_n = ~(&p);
        blk_gen_n  = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                     | (p[3] & p[2] & p[1] & g[0]));
    end
endmodule

// File: rtl/cla_adder64.sv
// Module: cla_adder64
// Two-level look-ahead adder over GROUPS*GROUPS slices of SLICE_W bits.
// The default is 64 bits. Four first-level units serve the slices.
// One second-level unit supplies their carry-ins.
// Purely combinational; no clock or reset.
module cla_adder64
    import cla_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic [SLICE_W*GROUPS*GROUPS-1:0] a,
    input  logic [SLICE_W*GROUPS*GROUPS-1:0] b,
    input  logic                             cin,
    output logic [SLICE_W*GROUPS*GROUPS-1:0] sum,
    output logic                             cout
);
    localparam int SLICES = GROUPS * GROUPS;
    localparam int WIDTH  = SLICE_W * SLICES;

    logic [SLICES-1:0] sl_g_n;
    logic [SLICES-1:0] sl_p_n;
    logic [SLICES-1:0] sl_cin;
    gp_vec_t           l1_g_n;
    gp_vec_t           l1_p_n;
    logic [GROUPS-1:0] l1_cin;
    logic              top_g_n;
    logic              top_p_n;

    // Adder slices
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        cla_slice #(.SLICE_W(SLICE_W)) u_slice (
            .a      (a[s*SLICE_W +: SLICE_W]),
            .b      (b[s*SLICE_W +: SLICE_W]),
            .c_in   (sl_cin[s]),
            .sum    (sum[s*SLICE_W +: SLICE_W]),
            .gen_n  (sl_g_n[s]),
            .prop_n (sl_p_n[s])
        );
    end

    // First-level units, one per four slices
    for (genvar j = 0; j < GROUPS; j++) begin : g_lvl1
        assign sl_cin[j*GROUPS] = l1_cin[j];
        cla_unit u_l1 (
            .gen_n      (sl_g_n[j*GROUPS +: GROUPS]),
            .prop_n     (sl_p_n[j*GROUPS +: GROUPS]),
            .c_in       (l1_cin[j]),
            .c_grp      (sl_cin[j*GROUPS+1 +: GROUPS-1]),
            .blk_gen_n  (l1_g_n[j]),
            .blk_prop_n (l1_p_n[j])
        );
    end

    // Second-level unit across the four first-level blocks
    assign l1_cin[0] = cin;
    cla_unit u_l2 (
        .gen_n      (l1_g_n),
        .prop_n     (l1_p_n),
        .c_in       (cin),
        .c_grp      (l1_cin[GROUPS-1:1]),
        .blk_gen_n  (top_g_n),
        .blk_prop_n (top_p_n)
    );

    // Word carry-out from the top block terms
    always_comb cout = ~top_g_n | (~top_p_n & cin);

    initial begin
        if (WIDTH != $bits(a)) $display("width mismatch");
    end
endmodule

// File: rtl/cla_adder64_chk.sv
// Module: cla_adder64_chk
// Checker bound to cla_adder64. It compares the port results with a plain
// sum, and the second-level carries with the first-level block terms.
module cla_adder64_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [3:0]       l1_g_n,
    input logic [3:0]       l1_p_n,
    input logic [3:0]       l1_cin,
    input logic             top_p_n
);
    logic [WIDTH:0] ref_sum;
    logic [3:0]     g;
    logic [3:0]     p;

    // Reference values
    always_comb begin
        ref_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        g = ~l1_g_n;
        p = ~l1_p_n;
    end

    // Port and tree consistency checks
    always_comb begin
        assert_sum_R7: assert (sum == ref_sum[WIDTH-1:0]);
        assert_cout_R8: assert (cout == ref_sum[WIDTH]);
        assert_c1_R1: assert (l1_cin[1] == (g[0] | (p[0] & cin)));
        assert_c2_R2: assert (l1_cin[2] == (g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin)));
        assert_c3_R3: assert (l1_cin[3] == (g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                                            | (p[2] & p[1] & p[0] & cin)));
        assert_blk_prop_R4: assert (top_p_n == (l1_p_n != 4'b0000));
    end
endmodule

bind cla_adder64 cla_adder64_chk #(.WIDTH(WIDTH)) u_chk (
    .a       (a),
    .b       (b),
    .cin     (cin),
    .sum     (sum),
    .cout    (cout),
    .l1_g_n  (l1_g_n),
    .l1_p_n  (l1_p_n),
    .l1_cin  (l1_cin),
    .top_p_n (top_p_n)
);

// File: tb/tb_cla_adder64.sv
module tb_cla_adder64;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [63:0] a, b, sum;
    logic        cin, cout;

    cla_adder64 dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

    logic [3:0] u_gn, u_pn;
    logic       u_cin;
    logic [2:0] u_c;
    logic       u_bg, u_bp;

    cla_unit u_unit (.gen_n(u_gn), .prop_n(u_pn), .c_in(u_cin),
                     .c_grp(u_c), .blk_gen_n(u_bg), .blk_prop_n(u_bp));

    function automatic logic [2:0] exp_carries(input logic [3:0] gn, pn, input logic c0);
        logic [2:0] r;
        logic c;
        c = c0;
        for (int k = 0; k < 3; k++) begin
            c = ~gn[k] | (~pn[k] & c);
            r[k] = c;
        end
        return r;
    endfunction

    function automatic logic exp_bgen_n(input logic [3:0] gn, pn);
        logic c;
        c = 1'b0;
        for (int k = 0; k < 4; k++) c = ~gn[k] | (~pn[k] & c);
        return ~c;
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic add_case(input logic [63:0] x, input logic [63:0] y, input logic c);
        logic [64:0] r;
        @(negedge clk);
        a = x; b = y; cin = c;
        r = {1'b0, x} + {1'b0, y} + {64'd0, c};
        @(posedge clk); #1;
        check("R7 sum", {1'b0, sum}, {1'b0, r[63:0]});
        check("R8 cout", {64'd0, cout}, {64'd0, r[64]});
    endtask

    initial begin
        #(10 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] keep_bg, keep_bp;
        void'($urandom(32'd20250611));
        a = '0; b = '0; cin = 1'b0;
        u_gn = '1; u_pn = '1; u_cin = 1'b0;
        @(posedge clk); #1;
        check("R7 zero state", {1'b0, sum}, 65'd0);
        check("R3 idle unit", {62'd0, u_c}, 65'd0);

        // Exhaustive unit sweep: cin toggles inside the pair to show R6
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                u_gn = v[3:0]; u_pn = v[7:4]; u_cin = c[0];
                @(posedge clk); #1;
                check("R1 c1", {64'd0, u_c[0]}, {64'd0, exp_carries(u_gn, u_pn, u_cin)[0]});
                check("R2 c2", {64'd0, u_c[1]}, {64'd0, exp_carries(u_gn, u_pn, u_cin)[1]});
                check("R3 c3", {64'd0, u_c[2]}, {64'd0, exp_carries(u_gn, u_pn, u_cin)[2]});
                check("R4 blk prop", {64'd0, u_bp}, {64'd0, (u_pn != 4'b0000)});
                check("R5 blk gen", {64'd0, u_bg}, {64'd0, exp_bgen_n(u_gn, u_pn)});
                if (c == 0) begin
                    keep_bg = {3'd0, u_bg}; keep_bp = {3'd0, u_bp};
                end else begin
                    check("R6 cin ignored gen", {64'd0, u_bg}, {64'd0, keep_bg[0]});
                    check("R6 cin ignored prop", {64'd0, u_bp}, {64'd0, keep_bp[0]});
                end
            end
        end

        // Directed corners for R7 and R8
        add_case('1, 64'd1, 1'b0);
        add_case('1, 64'd0, 1'b1);
        add_case('1, '1, 1'b1);
        add_case(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
        add_case(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
        add_case(64'h0000_FFFF_0000_FFFF, 64'h0000_0000_0000_0001, 1'b0);
        add_case(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1);
        add_case(64'h0FFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);

        // Seeded random operands, half of them biased toward long propagate runs
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] x, y;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (n[0]) y = ~x ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            add_case(x, y, 1'($urandom));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule